// File: doc/BRIEF.md
# Descriptor-Chained Frame Fetch Engine

This block feeds a display pipeline by pulling frames out of main memory. Each frame is described by a four-word record held in memory: a link to the following record, the byte address of the pixel words, an identifier, and a control word. Software writes the address of the first record while the engine is stopped and then sets the enable. From that point the engine reads a record, streams the words it describes into an internal pixel FIFO, and then follows the link to the next record. A link that points back at its own record makes the engine show one frame over and over.

The control word gives a 24-bit word count in bits 23:0, a start-of-frame interrupt request in bit 31 and an end-of-frame interrupt request in bit 30. Each requested event gives a one-cycle pulse and sets a sticky status bit. Software clears a status bit by writing 1 to it. Memory is reached through a read port with one request in flight at a time. All addresses are physical byte addresses.

The sequencer has seven named states:
- IDLE waits for the enable and copies the programmed first record address.
- DESC_REQ issues a record read.
- DESC_WAIT takes the response. It returns to DESC_REQ until the fourth word has arrived, then goes to FRAME_START.
- FRAME_START loads the frame address and word count. It goes to DATA_REQ, or straight to FRAME_END when the count is zero.
- DATA_REQ issues a pixel word read once the FIFO has room.
- DATA_WAIT pushes the response into the FIFO. It returns to DATA_REQ, or goes to FRAME_END after the last word.
- FRAME_END follows the link. It goes to DESC_REQ while the engine is enabled, or to IDLE when it is not.

Top module: `frame_fetch_engine`

## Requirements
- R1: After reset, `mem_req_valid`, `pix_valid`, `irq_status` and `frame_id` are all zero.
- R2: No memory request is made while `cfg_enable` is low after reset. Fetching begins only once `cfg_enable` is set, at the address on `cfg_first_desc`.
- R3: A record at byte address D is read as four requests, at D, D+4, D+8 and D+12, in that order. No new request is issued while a response is still outstanding.
- R4: A frame with base address S and count N (control bits 23:0) is read as N requests at S, S+4, and so on. The words appear on `pix_data` in the order they were read.
- R5: After a frame, the next record is read from the link word (first word) of the current record. A link equal to the record's own address repeats that frame indefinitely.
- R6: Start-of-frame events and end-of-frame events are each tracked in two ways:
  - The start-of-frame pulse comes after the record's fourth word and before the frame's first request, and only when control bit 31 is set.
  - The end-of-frame pulse comes after the frame's last response, and only when control bit 30 is set.
  - Each pulse sets a sticky bit in `irq_status`: bit 0 for start of frame, bit 1 for end of frame.
  - Writing 1 to a bit of `irq_clear` clears the matching status bit. A set in the same cycle takes priority over the clear.
- R7: A count of zero produces no pixel requests. The engine goes on to end-of-frame handling and then reads the next record.
- R8: No pixel request is issued while the pixel FIFO holds FIFO_DEPTH words. Requests resume once the consumer drains a word.
- R9: `frame_id` shows the third word of the most recently read record. Its value has no effect on fetching.
- R10: Clearing `cfg_enable` takes effect only at a frame end. The current frame completes, and then no further requests are issued.
- R11: A request held while `mem_req_ready` is low keeps `mem_req_valid` high and `mem_req_addr` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_enable | input | 1 | Run enable |
| cfg_first_desc | input | AW | Byte address of the first record |
| irq_clear | input | 2 | Write-1-to-clear for the status bits (bit 0 SOF, bit 1 EOF) |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_addr | output | AW | Read request byte address |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data |
| pix_valid | output | 1 | Pixel FIFO has a word |
| pix_data | output | 32 | Head word of the pixel FIFO |
| pix_ready | input | 1 | Consumer takes the head word |
| irq_sof_pulse | output | 1 | Start-of-frame event pulse |
| irq_eof_pulse | output | 1 | End-of-frame event pulse |
| irq_status | output | 2 | Sticky status, bit 0 SOF, bit 1 EOF |
| frame_id | output | 32 | Identifier of the latest record |

## Verification
The assertions check the following on every cycle:
- a stalled request is held steady;
- there is never more than one read in flight;
- every address is word-aligned;
- the FIFO never exceeds its depth;
- each event pulse sets its status bit on the next cycle;
- the two pulses never coincide.

The sweep covers every count from zero to five under every pair of interrupt enables. Only those bench scenarios can show the address order through record, frame and self-linked record, and the delivered pixel order. The same holds for where each pulse falls relative to the requests, the write-1-to-clear behaviour, and the FIFO back-pressure stall. They also show that a disable stops the engine only on a frame boundary.

// File: rtl/ffe_pkg.sv
package ffe_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DESC_REQ,
        ST_DESC_WAIT,
        ST_FRAME_START,
        ST_DATA_REQ,
        ST_DATA_WAIT,
        ST_FRAME_END
    } ffe_state_e;

    localparam int SOF_EN_BIT   = 31;
    localparam int EOF_EN_BIT   = 30;
    localparam int REC_WORDS    = 4;
    localparam int IRQ_SOF      = 0;
    localparam int IRQ_EOF      = 1;
endpackage

// File: rtl/ffe_pixel_fifo.sv
module ffe_pixel_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 4,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic             out_valid,
    output logic [WIDTH-1:0] out_data,
    output logic [CNT_W-1:0] level
);
    logic [WIDTH-1:0] store_q [DEPTH];
    logic [PTR_W-1:0] wr_q, rd_q;
    logic [CNT_W-1:0] cnt_q;
    logic             do_push, do_pop;

    assign do_push   = push && (cnt_q < CNT_W'(DEPTH));
    assign do_pop    = pop && (cnt_q != '0);
    assign out_valid = (cnt_q != '0);
    assign out_data  = store_q[rd_q];
    assign level     = cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) begin
                wr_q <= (wr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
            end
            if (do_pop) begin
                rd_q <= (rd_q == PTR_W'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
            end
            cnt_q <= cnt_q + CNT_W'(do_push) - CNT_W'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) begin
            store_q[wr_q] <= push_data;
        end
    end
endmodule

// File: rtl/ffe_irq_unit.sv
module ffe_irq_unit (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sof_evt,
    input  logic       eof_evt,
    input  logic [1:0] clear,
    output logic [1:0] status
);
    import ffe_pkg::*;

    logic [1:0] stat_q;
    logic [1:0] set_v;

    always_comb begin
        set_v          = '0;
        set_v[IRQ_SOF] = sof_evt;
        set_v[IRQ_EOF] = eof_evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q <= '0;
        end else begin
            stat_q <= set_v | (stat_q & ~clear);
        end
    end

    assign status = stat_q;
endmodule

// File: rtl/frame_fetch_engine.sv
module frame_fetch_engine #(
    parameter int AW         = 32,
    parameter int CNT_W      = 24,
    parameter int FIFO_DEPTH = 4,
    localparam int FIFO_LVL_W = $clog2(FIFO_DEPTH + 1),
    localparam int IDX_W      = $clog2(ffe_pkg::REC_WORDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_enable,
    input  logic [AW-1:0] cfg_first_desc,
    input  logic [1:0]    irq_clear,
    output logic          mem_req_valid,
    output logic [AW-1:0] mem_req_addr,
    input  logic          mem_req_ready,
    input  logic          mem_rsp_valid,
    input  logic [31:0]   mem_rsp_data,
    output logic          pix_valid,
    output logic [31:0]   pix_data,
    input  logic          pix_ready,
    output logic          irq_sof_pulse,
    output logic          irq_eof_pulse,
    output logic [1:0]    irq_status,
    output logic [31:0]   frame_id
);
    import ffe_pkg::*;

    ffe_state_e           state_q, state_d;
    logic [AW-1:0]        rec_ptr_q, link_q, base_q, addr_q;
    logic [31:0]          fid_q;
    logic [CNT_W-1:0]     count_q, left_q;
    logic                 sof_en_q, eof_en_q;
    logic [IDX_W-1:0]     widx_q;
    logic [FIFO_LVL_W-1:0] fifo_cnt;
    logic                 fifo_room, fifo_push;

    assign fifo_room = (fifo_cnt < FIFO_LVL_W'(FIFO_DEPTH));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:        if (cfg_enable) state_d = ST_DESC_REQ;
            ST_DESC_REQ:    if (mem_req_ready) state_d = ST_DESC_WAIT;
            ST_DESC_WAIT:   if (mem_rsp_valid)
                                state_d = (widx_q == IDX_W'(REC_WORDS - 1)) ? ST_FRAME_START : ST_DESC_REQ;
            ST_FRAME_START: state_d = (count_q == '0) ? ST_FRAME_END : ST_DATA_REQ;
            ST_DATA_REQ:    if (fifo_room && mem_req_ready) state_d = ST_DATA_WAIT;
            ST_DATA_WAIT:   if (mem_rsp_valid)
                                state_d = (left_q == CNT_W'(1)) ? ST_FRAME_END : ST_DATA_REQ;
            ST_FRAME_END:   state_d = cfg_enable ? ST_DESC_REQ : ST_IDLE;
            default:        state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        mem_req_valid = 1'b0;
        mem_req_addr  = addr_q;
        fifo_push     = 1'b0;
        irq_sof_pulse = 1'b0;
        irq_eof_pulse = 1'b0;
        unique case (state_q)
            ST_DESC_REQ: begin
                mem_req_valid = 1'b1;
                mem_req_addr  = rec_ptr_q + AW'({widx_q, 2'b00});
            end
            ST_DATA_REQ:    mem_req_valid = fifo_room;
            ST_DATA_WAIT:   fifo_push     = mem_rsp_valid;
            ST_FRAME_START: irq_sof_pulse = sof_en_q;
            ST_FRAME_END:   irq_eof_pulse = eof_en_q;
            default: ;
        endcase
    end

    // record and frame datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rec_ptr_q <= '0;
            link_q    <= '0;
            base_q    <= '0;
            addr_q    <= '0;
            fid_q     <= '0;
            count_q   <= '0;
            left_q    <= '0;
            sof_en_q  <= 1'b0;
            eof_en_q  <= 1'b0;
            widx_q    <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    rec_ptr_q <= cfg_first_desc;
                    widx_q    <= '0;
                end
                ST_DESC_WAIT: if (mem_rsp_valid) begin
                    unique case (widx_q)
                        2'd0: link_q <= mem_rsp_data[AW-1:0];
                        2'd1: base_q <= mem_rsp_data[AW-1:0];
                        2'd2: fid_q  <= mem_rsp_data;
                        default: begin
                            sof_en_q <= mem_rsp_data[SOF_EN_BIT];
                            eof_en_q <= mem_rsp_data[EOF_EN_BIT];
                            count_q  <= mem_rsp_data[CNT_W-1:0];
                        end
                    endcase
                    widx_q <= widx_q + 1'b1;
                end
                ST_FRAME_START: begin
                    addr_q <= base_q;
                    left_q <= count_q;
                end
                ST_DATA_WAIT: if (mem_rsp_valid) begin
                    addr_q <= addr_q + AW'(4);
                    left_q <= left_q - 1'b1;
                end
                ST_FRAME_END: begin
                    rec_ptr_q <= link_q;
                    widx_q    <= '0;
                end
                default: ;
            endcase
        end
    end

    assign frame_id = fid_q;

    ffe_pixel_fifo #(.WIDTH(32), .DEPTH(FIFO_DEPTH)) fifo_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (fifo_push),
        .push_data (mem_rsp_data),
        .pop       (pix_ready),
        .out_valid (pix_valid),
        .out_data  (pix_data),
        .level     (fifo_cnt)
    );

    ffe_irq_unit irq_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .sof_evt (irq_sof_pulse),
        .eof_evt (irq_eof_pulse),
        .clear   (irq_clear),
        .status  (irq_status)
    );
endmodule

// File: rtl/ffe_checker.sv
module ffe_checker #(
    parameter int AW         = 32,
    parameter int FIFO_DEPTH = 4,
    parameter int LVL_W      = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mem_req_valid,
    input logic             mem_req_ready,
    input logic [AW-1:0]    mem_req_addr,
    input logic             mem_rsp_valid,
    input logic [LVL_W-1:0] fifo_cnt,
    input logic             irq_sof_pulse,
    input logic             irq_eof_pulse,
    input logic [1:0]       irq_status
);
    logic inflight_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            inflight_q <= 1'b0;
        end else begin
            inflight_q <= (inflight_q && !mem_rsp_valid) || (mem_req_valid && mem_req_ready);
        end
    end

    p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

    p_single_inflight_r3: assert property (@(posedge clk) disable iff (!rst_n)
        inflight_q |-> !mem_req_valid);

    p_word_aligned_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> mem_req_addr[1:0] == 2'b00);

    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_cnt <= LVL_W'(FIFO_DEPTH));

    p_sof_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_sof_pulse |=> irq_status[0]);

    p_eof_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_eof_pulse |=> irq_status[1]);

    p_pulses_apart_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_sof_pulse && irq_eof_pulse));
endmodule

bind frame_fetch_engine ffe_checker #(
    .AW(AW), .FIFO_DEPTH(FIFO_DEPTH), .LVL_W(FIFO_LVL_W)
) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .fifo_cnt      (fifo_cnt),
    .irq_sof_pulse (irq_sof_pulse),
    .irq_eof_pulse (irq_eof_pulse),
    .irq_status    (irq_status)
);

// File: tb/frame_fetch_engine_tb.sv
module frame_fetch_engine_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int AW         = 32;
    localparam int FIFO_DEPTH = 4;
    localparam int LOG_N      = 2048;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_enable = 1'b0;
    logic [AW-1:0] cfg_first_desc = '0;
    logic [1:0]    irq_clear = '0;
    logic          mem_req_valid;
    logic [AW-1:0] mem_req_addr;
    logic          mem_req_ready = 1'b0;
    logic          mem_rsp_valid = 1'b0;
    logic [31:0]   mem_rsp_data = '0;
    logic          pix_valid;
    logic [31:0]   pix_data;
    logic          pix_ready = 1'b0;
    logic          irq_sof_pulse, irq_eof_pulse;
    logic [1:0]    irq_status;
    logic [31:0]   frame_id;

    frame_fetch_engine #(.AW(AW), .FIFO_DEPTH(FIFO_DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_first_desc(cfg_first_desc),
        .irq_clear(irq_clear), .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .mem_req_ready(mem_req_ready), .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .pix_valid(pix_valid), .pix_data(pix_data), .pix_ready(pix_ready),
        .irq_sof_pulse(irq_sof_pulse), .irq_eof_pulse(irq_eof_pulse),
        .irq_status(irq_status), .frame_id(frame_id)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    logic [31:0] mem [256];
    logic [31:0] req_log [LOG_N];
    logic [31:0] pix_log [LOG_N];
    int req_n = 0, pix_n = 0, sof_n = 0, eof_n = 0;
    int sof_last_req = 0, eof_last_req = 0;
    logic [31:0] eof_last_fid = '0;
    int hold_viol = 0;
    bit pix_stall = 1'b0;
    int checks = 0, failures = 0;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // memory responder and pixel consumer
    initial begin
        int cyc = 0, lat = 0;
        bit acc = 0, pend = 0, hold = 0;
        logic [7:0] paddr = '0;
        logic [31:0] haddr = '0;
        forever begin
            @(negedge clk);
            cyc++;
            if (mem_rsp_valid) mem_rsp_valid = 1'b0;
            if (acc) begin
                pend = 1; lat = cyc % 3; acc = 0;
            end else if (pend) begin
                if (lat == 0) begin
                    mem_rsp_valid = 1'b1; mem_rsp_data = mem[paddr]; pend = 0;
                end else lat--;
            end
            if (irq_sof_pulse) begin sof_n++; sof_last_req = req_n; end
            if (irq_eof_pulse) begin eof_n++; eof_last_req = req_n; eof_last_fid = frame_id; end
            if (hold && !(mem_req_valid && mem_req_addr == haddr)) hold_viol++;
            mem_req_ready = (cyc % 3) != 1;
            hold = mem_req_valid && !mem_req_ready;
            haddr = mem_req_addr;
            if (mem_req_valid && mem_req_ready) begin
                acc = 1; paddr = mem_req_addr[9:2];
                if (req_n < LOG_N) req_log[req_n] = mem_req_addr;
                req_n++;
            end
            pix_ready = !pix_stall && ((cyc % 4) != 3);
            if (pix_valid && pix_ready) begin
                if (pix_n < LOG_N) pix_log[pix_n] = pix_data;
                pix_n++;
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++; checks++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic do_reset();
        cfg_enable = 1'b0;
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!mem_req_valid, "R1 req_valid", 32'(mem_req_valid), 0);
        chk(!pix_valid, "R1 pix_valid", 32'(pix_valid), 0);
        chk(irq_status == 0, "R1 status", 32'(irq_status), 0);
        chk(frame_id == 0, "R1 frame_id", frame_id, 0);
    endtask

    function automatic logic [31:0] exp_addr(int k, int cnt);
        int j;
        if (k < 4) return 32'h40 + 32'(4*k);
        if (k < 4 + cnt) return 32'h200 + 32'(4*(k-4));
        j = (k - 4 - cnt) % 6;
        if (j < 4) return 32'h80 + 32'(4*j);
        return 32'h300 + 32'(4*(j-4));
    endfunction

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 32'hC0DE_0000 + 32'(i);
        for (int cnt = 0; cnt <= 5; cnt++) begin
            for (int fl = 0; fl < 4; fl++) begin
                int rb, pb, sb, eb, dreq, fin;
                logic [31:0] exp;
                // record A at 0x40 links to B at 0x80; B links to itself
                mem[16] = 32'h80; mem[17] = 32'h200; mem[18] = 32'hA000 + 32'(cnt*4+fl);
                mem[19] = (32'(fl & 1) << 31) | (32'((fl >> 1) & 1) << 30) | 32'(cnt);
                mem[32] = 32'h80; mem[33] = 32'h300; mem[34] = 32'hB0; mem[35] = 32'd2;
                do_reset();
                cfg_first_desc = 32'h40;
                rb = req_n; pb = pix_n; sb = sof_n; eb = eof_n;
                repeat (10) @(negedge clk);
                chk(req_n == rb, "R2 no fetch while disabled", 32'(req_n - rb), 0);
                cfg_enable = 1'b1;
                while (req_n - rb < 4 + cnt + 12) @(negedge clk);
                cfg_enable = 1'b0;
                repeat (60) @(negedge clk);
                fin = req_n;
                repeat (40) @(negedge clk);
                chk(req_n == fin, "R10 stopped", 32'(req_n), 32'(fin));
                chk(((fin - rb - 4 - cnt) % 6) == 0, "R10 frame boundary", 32'(fin - rb), 32'(4 + cnt));
                dreq = 0;
                for (int k = 0; k < fin - rb; k++) begin
                    exp = exp_addr(k, cnt);
                    if (exp >= 32'h200) dreq++;
                    if (k < 4)
                        chk(req_log[rb+k] == exp, "R3 record addr", req_log[rb+k], exp);
                    else if (k < 4 + cnt)
                        chk(req_log[rb+k] == exp, "R4 frame addr", req_log[rb+k], exp);
                    else if (cnt == 0 && k < 8)
                        chk(req_log[rb+k] == exp, "R7 zero count next record", req_log[rb+k], exp);
                    else
                        chk(req_log[rb+k] == exp, "R5 link/self repeat addr", req_log[rb+k], exp);
                end
                chk(pix_n - pb == dreq, "R4 pixel count", 32'(pix_n - pb), 32'(dreq));
                for (int i = 0; i < pix_n - pb; i++) begin
                    exp = (i < cnt) ? 32'hC0DE_0080 + 32'(i) : 32'hC0DE_00C0 + 32'((i - cnt) % 2);
                    chk(pix_log[pb+i] == exp, "R4 pixel data", pix_log[pb+i], exp);
                end
                chk(sof_n - sb == (fl & 1), "R6 sof count", 32'(sof_n - sb), 32'(fl & 1));
                if (fl & 1) chk(sof_last_req - rb == 4, "R6 sof position", 32'(sof_last_req - rb), 4);
                chk(eof_n - eb == ((fl >> 1) & 1), "R6 eof count", 32'(eof_n - eb), 32'((fl >> 1) & 1));
                if (fl & 2) begin
                    chk(eof_last_req - rb == 4 + cnt, "R6 eof position", 32'(eof_last_req - rb), 32'(4 + cnt));
                    chk(eof_last_fid == 32'hA000 + 32'(cnt*4+fl), "R9 id of A", eof_last_fid, 32'hA000 + 32'(cnt*4+fl));
                end
                chk(frame_id == 32'hB0, "R9 id of B", frame_id, 32'hB0);
                chk(irq_status == 2'(fl), "R6 sticky status", 32'(irq_status), 32'(fl));
                irq_clear = 2'b01; @(negedge clk); irq_clear = 2'b00; @(negedge clk);
                chk(irq_status == 2'(fl & 2), "R6 clear sof", 32'(irq_status), 32'(fl & 2));
                irq_clear = 2'b10; @(negedge clk); irq_clear = 2'b00; @(negedge clk);
                chk(irq_status == 0, "R6 clear eof", 32'(irq_status), 0);
            end
        end
        begin
            int rb, pb;
            logic [31:0] exp;
            mem[64] = 32'h100; mem[65] = 32'h200; mem[66] = 32'h7; mem[67] = 32'd10;
            do_reset();
            cfg_first_desc = 32'h100;
            pix_stall = 1'b1;
            rb = req_n; pb = pix_n;
            cfg_enable = 1'b1;
            repeat (80) @(negedge clk);
            chk(req_n - rb == 4 + FIFO_DEPTH, "R8 stall at full", 32'(req_n - rb), 32'(4 + FIFO_DEPTH));
            chk(pix_valid, "R8 fifo holds data", 32'(pix_valid), 1);
            cfg_enable = 1'b0;
            pix_stall = 1'b0;
            repeat (200) @(negedge clk);
            chk(req_n - rb == 14, "R8 resume and R10 stop", 32'(req_n - rb), 14);
            chk(pix_n - pb == 10, "R8 pixel count", 32'(pix_n - pb), 10);
            for (int i = 0; i < 10; i++) begin
                exp = 32'hC0DE_0080 + 32'(i);
                chk(pix_log[pb+i] == exp, "R8 pixel order", pix_log[pb+i], exp);
            end
        end
        chk(hold_viol == 0, "R11 held request", 32'(hold_viol), 0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule